// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the clock line of an I2C master from a fast peripheral clock. A power-of-two prescaler turns the peripheral clock into a base tick, and two independent 4-bit counts decide how many base ticks SCL is held low and how many it is left released. The command engine that owns START, STOP and data shifting sits beside it. It uses two one-cycle strobes from this block: one in the middle of each low phase, when SDA may change, and one in the middle of each high phase, when SDA is sampled.

The low phase is fully timed by the block. At the end of it the block releases SCL and waits. The high-phase count starts only after the sampled line really reads high, so a target that stretches the clock simply lengthens the high phase. In fast mode a non-zero timeout selection limits how long such a stretch may last before a one-cycle timeout strobe is raised. With enable low, every counter is cleared and SCL is left released. Configuration inputs are expected to be steady while enable is high.

Top module: `scl_timing_gen`

## Requirements
- R1: Both in reset and in the cycle after enable is sampled low, `scl_drive_low`, `sda_change`, `sda_sample` and `scl_timeout` are all 0.
- R2: The base tick period is 2^`div_exp` peripheral clock cycles, with `div_exp` in 0..15. Every phase length below is a multiple of it.
- R3: Once enabled, each low phase keeps `scl_drive_low` at 1 for exactly (`low_cnt`+1)·2^`div_exp` cycles. The first low phase begins the cycle after enable is sampled high.
- R4: After release, the high count starts in the cycle after `scl_in` is sampled at 1. SCL then stays released for a further (`high_cnt`+1)·2^`div_exp` cycles, so an unstretched released phase lasts 1+(`high_cnt`+1)·2^`div_exp` cycles.
- R5: While `scl_in` reads 0 after release (clock stretching), `scl_drive_low` stays 0 and the high count does not advance. A stretch lasting S released cycles gives a released phase of S+(`high_cnt`+1)·2^`div_exp` cycles.
- R6: `sda_change` pulses exactly once per low phase, ((`low_cnt`+1)>>1)·2^`div_exp` cycles after the phase's first cycle, and only while `scl_drive_low` is 1.
- R7: `sda_sample` pulses exactly once per released phase, ((`high_cnt`+1)>>1)·2^`div_exp` cycles after the high count starts, and only while `scl_drive_low` is 0.
- R8: With `fast_mode`=1 and `tmo_sel`≠0, a stretch that lasts `tmo_sel`·TMO_UNIT base ticks produces exactly one `scl_timeout` pulse. The pulse falls on the last cycle of that tick count, measured from release.
- R9: With `fast_mode`=0, or with `tmo_sel`=0, `scl_timeout` never pulses, however long the stretch.
- R10: Dropping enable in the middle of a low phase releases SCL in the next cycle. Raising it again starts a fresh low phase of full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run the SCL timing; 0 clears all counters and releases SCL |
| fast_mode | input | 1 | Fast timing mode; allows the stretch timeout |
| div_exp | input | 4 | Prescaler exponent; base tick = 2^div_exp cycles |
| low_cnt | input | 4 | Low phase length minus one, in base ticks |
| high_cnt | input | 4 | High phase length minus one, in base ticks |
| tmo_sel | input | 3 | Stretch timeout in units of TMO_UNIT ticks; 0 disables |
| scl_in | input | 1 | Sampled (already synchronised) SCL line level |
| scl_drive_low | output | 1 | 1 requests the pad to pull SCL low |
| sda_change | output | 1 | One-cycle strobe in the middle of the low phase |
| sda_sample | output | 1 | One-cycle strobe in the middle of the high phase |
| scl_timeout | output | 1 | One-cycle strobe when a stretch exceeds the timeout |

## Verification
On every cycle the assertions check the cycle-local rules. Enable low always yields idle outputs. The data strobes appear only in their own phase and never together. A freshly released line that reads low keeps SCL released. The timeout strobe appears only during a permitted stretch. The exact lengths of the phases, the strobe offsets, the stretch extension, the single timeout pulse and the restart after enable drops depend on counts across many cycles. Only the bench's measured scenarios show them, across several prescaler exponents and count extremes.

// File: rtl/scl_timing_pkg.sv
// Shared types for the SCL timing generator.
// Assumes: nothing beyond standard SystemVerilog packages.
package scl_timing_pkg;

    // Phase of the SCL waveform as seen by the phase sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

endpackage

// File: rtl/scl_prescaler.sv
// Power-of-two base tick generator.
// Produces 'tick' on the last cycle of every 2^div_exp cycle window and
// 'tick_first' on the first cycle of the window. 'restart' realigns the
// window so a new phase always starts on a full tick.
// Assumes: div_exp is stable while en is high.
module scl_prescaler #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [EXP_W-1:0] div_exp,
    output logic             tick,
    output logic             tick_first
);
    localparam int PRE_W = (1 << EXP_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] win_last;

    // Last count value of the current window
    assign win_last   = (PRE_W'(1) << div_exp) - PRE_W'(1);
    assign tick       = en && (pre_cnt >= win_last);
    assign tick_first = en && (pre_cnt == '0);

    // Window counter: cleared on reset, disable or restart, wraps on tick
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/scl_phase_fsm.sv
// SCL phase sequencer.
// Steps through low, wait-for-line-high and high phases, counting base
// ticks in the timed phases. It asks the prescaler to realign on every phase
// change and decodes the mid-phase SDA strobes.
// Assumes: scl_in is already synchronised; counts are stable while en is high.
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             tick_first,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic             scl_in,
    output logic             restart,
    output logic             drive_low,
    output logic             in_wait,
    output logic             sda_change,
    output logic             sda_sample
);
    phase_e           phase_q;
    phase_e           phase_d;
    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W:0]   mid_low;
    logic [CNT_W:0]   mid_high;
    logic             timed;

    // Next phase selection
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: phase_d = PH_LOW;
            PH_LOW:  if (tick && tick_cnt == low_cnt)  phase_d = PH_WAIT;
            PH_WAIT: if (scl_in)                       phase_d = PH_HIGH;
            PH_HIGH: if (tick && tick_cnt == high_cnt) phase_d = PH_LOW;
            default: phase_d = PH_IDLE;
        endcase
        if (!en) phase_d = PH_IDLE;
    end

    assign restart = en && (phase_d != phase_q);
    assign timed   = (phase_q == PH_LOW) || (phase_q == PH_HIGH);

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Tick counter within a timed phase
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            tick_cnt <= '0;
        end else if (tick && timed) begin
            tick_cnt <= tick_cnt + CNT_W'(1);
        end
    end

    // Midpoints in ticks, rounded down on the phase length
    assign mid_low  = ({1'b0, low_cnt}  + (CNT_W+1)'(1)) >> 1;
    assign mid_high = ({1'b0, high_cnt} + (CNT_W+1)'(1)) >> 1;

    assign drive_low  = (phase_q == PH_LOW);
    assign in_wait    = (phase_q == PH_WAIT);
    assign sda_change = (phase_q == PH_LOW)  && tick_first && ({1'b0, tick_cnt} == mid_low);
    assign sda_sample = (phase_q == PH_HIGH) && tick_first && ({1'b0, tick_cnt} == mid_high);
endmodule

// File: rtl/scl_stretch_timer.sv
// Clock stretch timeout monitor.
// Counts base ticks while the sequencer waits for SCL to rise. It emits one
// strobe when the count reaches tmo_sel*TMO_UNIT, and only in fast mode
// with a non-zero selection.
// Assumes: tmo_sel and fast_mode are stable during a stretch.
module scl_stretch_timer #(
    parameter int TMO_W    = 3,
    parameter int TMO_UNIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_wait,
    input  logic             tick,
    input  logic             fast_mode,
    input  logic [TMO_W-1:0] tmo_sel,
    output logic             timeout
);
    localparam int LIM_W = TMO_W + $clog2(TMO_UNIT) + 1;

    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] wait_cnt;
    logic             armed;

    assign limit = LIM_W'(tmo_sel) * LIM_W'(TMO_UNIT);
    assign armed = fast_mode && (tmo_sel != '0);

    // Stretch tick counter, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || !in_wait) begin
            wait_cnt <= '0;
        end else if (armed && tick && (wait_cnt < limit)) begin
            wait_cnt <= wait_cnt + LIM_W'(1);
        end
    end

    assign timeout = in_wait && armed && tick && (wait_cnt == limit - LIM_W'(1));
endmodule

// File: rtl/scl_timing_gen.sv
// I2C SCL timing generator top.
// Ties the prescaler, the phase sequencer and the stretch timer together and
// presents the SCL drive request and the SDA phase strobes.
// Assumes: scl_in is synchronised to clk; configuration changes only while
// en is low.
module scl_timing_gen #(
    parameter int EXP_W    = 4,
    parameter int CNT_W    = 4,
    parameter int TMO_W    = 3,
    parameter int TMO_UNIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fast_mode,
    input  logic [EXP_W-1:0] div_exp,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic [TMO_W-1:0] tmo_sel,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             sda_change,
    output logic             sda_sample,
    output logic             scl_timeout
);
    logic tick;
    logic tick_first;
    logic restart;
    logic in_wait;

    scl_prescaler #(.EXP_W(EXP_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .restart    (restart),
        .div_exp    (div_exp),
        .tick       (tick),
        .tick_first (tick_first)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .tick       (tick),
        .tick_first (tick_first),
        .low_cnt    (low_cnt),
        .high_cnt   (high_cnt),
        .scl_in     (scl_in),
        .restart    (restart),
        .drive_low  (scl_drive_low),
        .in_wait    (in_wait),
        .sda_change (sda_change),
        .sda_sample (sda_sample)
    );

    scl_stretch_timer #(.TMO_W(TMO_W), .TMO_UNIT(TMO_UNIT)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_wait   (in_wait),
        .tick      (tick),
        .fast_mode (fast_mode),
        .tmo_sel   (tmo_sel),
        .timeout   (scl_timeout)
    );
endmodule

// File: rtl/scl_timing_gen_chk.sv
// Port-level checker for scl_timing_gen, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module scl_timing_gen_chk #(
    parameter int TMO_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             fast_mode,
    input logic [TMO_W-1:0] tmo_sel,
    input logic             scl_in,
    input logic             scl_drive_low,
    input logic             sda_change,
    input logic             sda_sample,
    input logic             scl_timeout
);
    // R1: disabled block is idle on the following cycle
    a_r1_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_drive_low && !sda_change && !sda_sample && !scl_timeout));

    // R6: data-change strobe only inside the low phase
    a_r6_change_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |-> scl_drive_low);

    // R7: sample strobe only while SCL is released
    a_r7_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample |-> (!scl_drive_low && !sda_change));

    // R5: a just-released line still held low keeps SCL released
    a_r5_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !scl_drive_low && !scl_in && $past(scl_drive_low)) |=> !scl_drive_low);

    // R8/R9: timeout only during a permitted stretch
    a_r9_timeout_gated: assert property (@(posedge clk) disable iff (!rst_n)
        scl_timeout |-> (!scl_drive_low && !scl_in && fast_mode && (tmo_sel != '0)));
endmodule

bind scl_timing_gen scl_timing_gen_chk #(.TMO_W(TMO_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .fast_mode     (fast_mode),
    .tmo_sel       (tmo_sel),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .sda_change    (sda_change),
    .sda_sample    (sda_sample),
    .scl_timeout   (scl_timeout)
);

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
    localparam int TMO_UNIT = 4;

    // {div_exp, low_cnt, high_cnt}
    localparam logic [11:0] VEC [0:6] = '{
        12'h000, 12'h032, 12'h125, 12'h2F0, 12'h344, 12'h0FF, 12'h413
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       fast_mode = 1'b0;
    logic [3:0] div_exp = '0;
    logic [3:0] low_cnt = '0;
    logic [3:0] high_cnt = '0;
    logic [2:0] tmo_sel = '0;
    logic       hold = 1'b0;
    logic       scl_in;
    logic       scl_drive_low, sda_change, sda_sample, scl_timeout;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    // Open-drain line: low when driven by the block or held by a target
    assign scl_in = ~scl_drive_low & ~hold;

    scl_timing_gen #(.TMO_UNIT(TMO_UNIT)) u_scl_timing_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .fast_mode(fast_mode),
        .div_exp(div_exp), .low_cnt(low_cnt), .high_cnt(high_cnt),
        .tmo_sel(tmo_sel), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
        .sda_change(sda_change), .sda_sample(sda_sample), .scl_timeout(scl_timeout)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic configure(input int e, input int l, input int h);
        @(negedge clk);
        en = 1'b0;
        hold = 1'b0;
        div_exp = 4'(e);
        low_cnt = 4'(l);
        high_cnt = 4'(h);
        @(negedge clk);
        en = 1'b1;
    endtask

    // Measure one full low + released period, with a stretch of s cycles
    task automatic measure(input int s, output int lo_len, output int lo_mid,
                           output int n_chg, output int hi_len,
                           output int hi_mid, output int n_smp);
        lo_len = 0; lo_mid = -1; n_chg = 0;
        hi_len = 0; hi_mid = -1; n_smp = 0;
        while (scl_drive_low) @(negedge clk);
        while (!scl_drive_low) @(negedge clk);
        hold = (s > 1);
        while (scl_drive_low) begin
            if (sda_change) begin lo_mid = lo_len; n_chg++; end
            lo_len++;
            @(negedge clk);
        end
        while (!scl_drive_low) begin
            if (sda_sample) begin hi_mid = hi_len; n_smp++; end
            if (sda_change) n_chg++;
            hi_len++;
            if (hi_len == s) hold = 1'b0;
            @(negedge clk);
        end
    endtask

    // Hold the line after release and record timeout pulses
    task automatic stretch_timeout(input int e, input bit fm, input int ts,
                                   input int exp_cnt, input int exp_idx);
        int n = 0;
        int idx = -1;
        int drv = 0;
        configure(e, 1, 1);
        fast_mode = fm;
        tmo_sel = 3'(ts);
        while (!scl_drive_low) @(negedge clk);
        hold = 1'b1;
        while (scl_drive_low) @(negedge clk);
        for (int i = 1; i <= 80; i++) begin
            if (scl_timeout) begin n++; idx = i; end
            if (scl_drive_low) drv++;
            @(negedge clk);
        end
        check(fm && ts != 0 ? "R8 timeout count" : "R9 timeout disabled", n, exp_cnt);
        if (exp_cnt > 0) check("R8 timeout position", idx, exp_idx);
        check("R5 no drive during stretch", drv, 0);
        en = 1'b0;
        hold = 1'b0;
        fast_mode = 1'b0;
        tmo_sel = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lo_len, lo_mid, n_chg, hi_len, hi_mid, n_smp;
        en = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 reset drive", scl_drive_low, 0);
        check("R1 reset strobes", sda_change | sda_sample | scl_timeout, 0);
        rst_n = 1'b1;
        en = 1'b0;

        // R2 R3 R4 R6 R7: table of configurations
        for (int v = 0; v < 7; v++) begin
            int e, l, h, d;
            e = int'(VEC[v][11:8]);
            l = int'(VEC[v][7:4]);
            h = int'(VEC[v][3:0]);
            d = 1 << e;
            configure(e, l, h);
            measure(1, lo_len, lo_mid, n_chg, hi_len, hi_mid, n_smp);
            check("R3 low length (R2 tick)", lo_len, (l + 1) * d);
            check("R4 released length (R2 tick)", hi_len, 1 + (h + 1) * d);
            check("R6 change offset", lo_mid, ((l + 1) >> 1) * d);
            check("R6 change count", n_chg, 1);
            check("R7 sample offset", hi_mid, 1 + ((h + 1) >> 1) * d);
            check("R7 sample count", n_smp, 1);
        end

        // R5: stretch of 7 cycles, exp=1 low=1 high=2
        configure(1, 1, 2);
        measure(7, lo_len, lo_mid, n_chg, hi_len, hi_mid, n_smp);
        check("R5 stretched released length", hi_len, 7 + 3 * 2);
        check("R5 stretched sample offset", hi_mid, 7 + 1 * 2);
        check("R5 stretched sample count", n_smp, 1);

        // R8 R9: timeout behaviour
        stretch_timeout(0, 1'b1, 1, 1, TMO_UNIT * 1 * 1);
        stretch_timeout(1, 1'b1, 2, 1, TMO_UNIT * 2 * 2);
        stretch_timeout(0, 1'b0, 3, 0, 0);
        stretch_timeout(0, 1'b1, 0, 0, 0);

        // R10 / R1: drop enable mid low phase, then restart
        configure(2, 5, 1);
        while (!scl_drive_low) @(negedge clk);
        repeat (6) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R10 released after disable", scl_drive_low, 0);
        check("R1 idle strobes when disabled", sda_change | sda_sample | scl_timeout, 0);
        repeat (10) @(negedge clk);
        check("R1 stays released", scl_drive_low, 0);
        en = 1'b1;
        @(negedge clk);
        check("R10 low starts after enable", scl_drive_low, 1);
        lo_len = 0;
        while (scl_drive_low) begin lo_len++; @(negedge clk); end
        check("R10 fresh low length", lo_len, 6 * 4);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule